// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-on and keeps its contents refreshed. After reset it counts out a fixed power-up pause. It then runs a short series of warm-up refresh cycles and only after that raises a ready flag, which tells the access controller that normal reads and writes may begin. From then on an interval timer adds one refresh to a pending count at a fixed spacing. With the default parameters the spacing is 15.6 µs at 100 MHz, which gives 2048 refreshes every 32 ms.

Every refresh uses the CAS-before-RAS ordering. The memory supplies the row internally, so the block has no address output. The block shares the strobe lines with the access controller. It asks for them on `refresh_req` and drives them only while `refresh_grant` is high, and it keeps `refresh_req` high until the whole cycle has ended, including the precharge. When the controller holds the grant back, refreshes wait in a saturating pending count rather than being lost. A burst input runs the full set of refreshes back to back and marks the end with a one-cycle pulse.

Top module: `dref_refresh_seq`

## Requirements
- R1: While reset is held and on the first cycle after release, `refresh_req`, `strobe_oe`, `ready`, `burst_done` and `overflow_err` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: `refresh_req` stays 0 for the first PWRUP_CYC-1 clock edges after reset release and becomes 1 after edge PWRUP_CYC.
- R3: After the pause, exactly WARM_CNT refresh cycles run before `ready` rises. `ready` then stays 1 until reset, and `refresh_req` drops in the same cycle that `ready` rises.
- R4: In each refresh cycle (`ras_n`, `cas_n` and `we_n` are active low), `cas_n` falls while `ras_n` is high. `ras_n` falls exactly T_CSR cycles later. `ras_n` stays low for exactly T_RAS cycles with `cas_n` low and `we_n` high, and both strobes then rise together. Before `cas_n` falls again, both strobes stay high for at least T_RP cycles.
- R5: `strobe_oe` is 1 only while `refresh_grant` is 1. No refresh cycle starts unless the grant is held, and `ras_n` does not fall while the grant is low.
- R6: Once the pause is over, one refresh is added to the pending count every INTERVAL_CYC cycles. Refreshes that arrive while the grant is withheld are all carried out once the grant returns, and `refresh_req` stays 1 until the last of them is done.
- R7: The pending count saturates at PEND_MAX. An interval that arrives while the count is full sets `overflow_err`, which stays 1 until reset. The refresh is then lost, so only PEND_MAX cycles are run afterwards.
- R8: A one-cycle pulse on `burst_start` while `ready` is 1 runs BURST_CNT refresh cycles, ahead of any pending refreshes. `burst_done` is then high for exactly one cycle, after the last of those cycles ends.
- R9: A `burst_start` pulse while `ready` is 0 is ignored. Only the warm-up cycles run, and `refresh_req` is 0 once `ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start | input | 1 | One-cycle request for a back-to-back refresh burst |
| refresh_grant | input | 1 | Access controller hands over the strobe lines |
| refresh_req | output | 1 | Refresh work pending or a cycle in progress |
| strobe_oe | output | 1 | The strobes below are driven by this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| ready | output | 1 | Power-up and warm-up complete |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| overflow_err | output | 1 | Sticky flag: a refresh was lost at saturation |

## Verification
A wrong pending count shows at the ports: after a withheld grant, the number of row-strobe falls before `refresh_req` drops differs from the number of elapsed intervals. This is visible within one service window. A mistake in the cycle-shape state machine changes the lead, low-width or precharge cycle counts on the very first refresh after the pause. A wrong warm-up or burst counter changes the number of falls seen before `ready` rises or before `burst_done` pulses. A fault in the saturation logic either raises `overflow_err` one interval too early or lets more than PEND_MAX cycles run.

// File: rtl/dref_pkg.sv
package dref_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_HOLD  = 2'd2,
      ST_PRECH = 2'd3
   } strobe_st_t;
endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
   parameter int unsigned PWRUP_CYC    = 20000,
   parameter int unsigned INTERVAL_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   output logic pwrup_done,
   output logic tick
);
   localparam int unsigned PW_W = $clog2(PWRUP_CYC + 1);
   localparam int unsigned IV_W = $clog2(INTERVAL_CYC + 1);
   localparam logic [PW_W-1:0] PW_LAST = PW_W'(PWRUP_CYC - 1);
   localparam logic [IV_W-1:0] IV_LAST = IV_W'(INTERVAL_CYC - 1);

   logic [PW_W-1:0] pw_cnt;
   logic [IV_W-1:0] iv_cnt;

   // Power-up pause: done goes high after PWRUP_CYC edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw_cnt     <= '0;
         pwrup_done <= 1'b0;
      end else if (!pwrup_done) begin
         if (pw_cnt == PW_LAST) pwrup_done <= 1'b1;
         else                   pw_cnt     <= pw_cnt + 1'b1;
      end
   end

   // Distributed interval: one tick per INTERVAL_CYC cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iv_cnt <= '0;
         tick   <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (pwrup_done) begin
            if (iv_cnt == IV_LAST) begin
               iv_cnt <= '0;
               tick   <= 1'b1;
            end else begin
               iv_cnt <= iv_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dref_pending.sv
module dref_pending #(
   parameter int unsigned PEND_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dec,
   output logic pend_nz,
   output logic overflow
);
   localparam int unsigned PD_W = $clog2(PEND_MAX + 1);
   localparam logic [PD_W-1:0] PD_TOP = PD_W'(PEND_MAX);

   logic [PD_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         overflow <= 1'b0;
      end else begin
         if (tick && !dec) begin
            if (cnt == PD_TOP) overflow <= 1'b1;
            else               cnt      <= cnt + 1'b1;
         end else if (dec && !tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign pend_nz = (cnt != '0);
endmodule

// File: rtl/dref_strobe.sv
module dref_strobe
   import dref_pkg::*;
#(
   parameter int unsigned T_CSR = 1,
   parameter int unsigned T_RAS = 6,
   parameter int unsigned T_RP  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic cyc_done,
   output logic ras_n,
   output logic cas_n
);
   localparam int unsigned T_A   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
   localparam int unsigned T_MAX = (T_A > T_RP) ? T_A : T_RP;
   localparam int unsigned CW    = $clog2(T_MAX + 1);
   localparam logic [CW-1:0] LD_LEAD = CW'(T_CSR - 1);
   localparam logic [CW-1:0] LD_HOLD = CW'(T_RAS - 1);
   localparam logic [CW-1:0] LD_PRE  = CW'(T_RP - 1);

   strobe_st_t st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st  <= ST_LEAD;
               cnt <= LD_LEAD;
            end
            ST_LEAD: if (cnt == '0) begin
               st  <= ST_HOLD;
               cnt <= LD_HOLD;
            end else cnt <= cnt - 1'b1;
            ST_HOLD: if (cnt == '0) begin
               st  <= ST_PRECH;
               cnt <= LD_PRE;
            end else cnt <= cnt - 1'b1;
            ST_PRECH: if (cnt == '0) begin
               st <= ST_IDLE;
            end else cnt <= cnt - 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign cyc_done = (st == ST_PRECH) && (cnt == '0);
   assign ras_n    = (st != ST_HOLD);
   assign cas_n    = !((st == ST_LEAD) || (st == ST_HOLD));
endmodule

// File: rtl/dref_refresh_seq.sv
module dref_refresh_seq #(
   parameter int unsigned PWRUP_CYC    = 20000,
   parameter int unsigned INTERVAL_CYC = 1560,
   parameter int unsigned WARM_CNT     = 8,
   parameter int unsigned BURST_CNT    = 2048,
   parameter bit          BURST_EN     = 1'b1,
   parameter int unsigned PEND_MAX     = 8,
   parameter int unsigned T_CSR        = 1,
   parameter int unsigned T_RAS        = 6,
   parameter int unsigned T_RP         = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic burst_start,
   input  logic refresh_grant,
   output logic refresh_req,
   output logic strobe_oe,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic ready,
   output logic burst_done,
   output logic overflow_err
);
   localparam int unsigned WW = $clog2(WARM_CNT + 1);
   localparam logic [WW-1:0] WARM_LOAD = WW'(WARM_CNT);
   localparam logic [WW-1:0] WARM_ONE  = WW'(1);

   // Elaboration-time parameter checks
   if (T_CSR < 1)        begin : g_bad_csr  $error("T_CSR must be at least 1");        end
   if (T_RAS < 1)        begin : g_bad_ras  $error("T_RAS must be at least 1");        end
   if (T_RP < 1)         begin : g_bad_rp   $error("T_RP must be at least 1");         end
   if (WARM_CNT < 1)     begin : g_bad_warm $error("WARM_CNT must be at least 1");     end
   if (PEND_MAX < 1)     begin : g_bad_pend $error("PEND_MAX must be at least 1");     end
   if (BURST_CNT < 1)    begin : g_bad_bst  $error("BURST_CNT must be at least 1");    end
   if (INTERVAL_CYC < 2) begin : g_bad_iv   $error("INTERVAL_CYC must be at least 2"); end
   if (PWRUP_CYC < 2)    begin : g_bad_pw   $error("PWRUP_CYC must be at least 2");    end

   logic pwrup_done, tick;
   logic pend_nz, busy, cyc_done, start;
   logic warm_nz, burst_act, work;
   logic dec_warm, dec_burst, dec_pend;
   logic [WW-1:0] warm_left;
   logic ready_q;

   dref_timer #(.PWRUP_CYC(PWRUP_CYC), .INTERVAL_CYC(INTERVAL_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done), .tick(tick));

   dref_pending #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dec(dec_pend),
      .pend_nz(pend_nz), .overflow(overflow_err));

   dref_strobe #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .cyc_done(cyc_done), .ras_n(ras_n), .cas_n(cas_n));

   assign warm_nz   = (warm_left != '0);
   assign work      = warm_nz | burst_act | pend_nz;
   assign start     = refresh_grant & pwrup_done & work & !busy;
   // Completed cycle is charged to warm-up first, then burst, then pending
   assign dec_warm  = cyc_done & warm_nz;
   assign dec_burst = cyc_done & !warm_nz & burst_act;
   assign dec_pend  = cyc_done & !warm_nz & !burst_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_left <= WARM_LOAD;
         ready_q   <= 1'b0;
      end else if (dec_warm) begin
         warm_left <= warm_left - 1'b1;
         if (warm_left == WARM_ONE) ready_q <= 1'b1;
      end
   end

   if (BURST_EN) begin : g_burst
      localparam int unsigned BW = $clog2(BURST_CNT + 1);
      localparam logic [BW-1:0] BURST_LOAD = BW'(BURST_CNT);
      localparam logic [BW-1:0] BURST_ONE  = BW'(1);
      logic [BW-1:0] burst_left;
      logic          bdone;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            burst_left <= '0;
            bdone      <= 1'b0;
         end else begin
            bdone <= 1'b0;
            if (burst_left == '0) begin
               if (burst_start && ready_q) burst_left <= BURST_LOAD;
            end else if (dec_burst) begin
               burst_left <= burst_left - 1'b1;
               if (burst_left == BURST_ONE) bdone <= 1'b1;
            end
         end
      end
      assign burst_act  = (burst_left != '0);
      assign burst_done = bdone;
   end else begin : g_no_burst
      assign burst_act  = 1'b0;
      assign burst_done = 1'b0;
   end

   assign refresh_req = pwrup_done & (work | busy);
   assign strobe_oe   = refresh_grant & busy;
   assign we_n        = 1'b1;
   assign ready       = ready_q;
endmodule

// File: rtl/dref_refresh_seq_chk.sv
module dref_refresh_seq_chk #(
   parameter int unsigned T_RAS = 6
) (
   input logic clk,
   input logic rst_n,
   input logic refresh_grant,
   input logic refresh_req,
   input logic strobe_oe,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic ready,
   input logic burst_done,
   input logic overflow_err
);
   logic [15:0] ras_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ras_low_cnt <= '0;
      else if (ras_n)                ras_low_cnt <= '0;
      else if (ras_low_cnt != '1)    ras_low_cnt <= ras_low_cnt + 1'b1;
   end

   AST_CBR_ORDER:     assert property (@(posedge clk) disable iff (!rst_n)
                         $fell(ras_n) |-> (!cas_n && $past(!cas_n)));           // R4
   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
                         !ras_n |-> !cas_n);                                     // R4
   AST_WE_HIGH:       assert property (@(posedge clk) disable iff (!rst_n)
                         !ras_n |-> we_n);                                       // R4
   AST_RAS_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n)
                         $rose(ras_n) |-> (ras_low_cnt >= 16'(T_RAS)));          // R4
   AST_OE_GRANT:      assert property (@(posedge clk) disable iff (!rst_n)
                         strobe_oe |-> refresh_grant);                           // R5
   AST_RAS_GRANT:     assert property (@(posedge clk) disable iff (!rst_n)
                         $fell(ras_n) |-> (refresh_grant && refresh_req));       // R5
   AST_READY_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
                         ready |=> ready);                                       // R3
   AST_OVF_STICKY:    assert property (@(posedge clk) disable iff (!rst_n)
                         overflow_err |=> overflow_err);                         // R7
   AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n)
                         burst_done |=> !burst_done);                            // R8
endmodule

bind dref_refresh_seq dref_refresh_seq_chk #(.T_RAS(T_RAS)) u_chk (
   .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant),
   .refresh_req(refresh_req), .strobe_oe(strobe_oe), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .ready(ready), .burst_done(burst_done),
   .overflow_err(overflow_err));

// File: tb/dref_refresh_seq_test.sv
module dref_refresh_seq_test;
   localparam int PW   = 50;
   localparam int IV   = 200;
   localparam int WARM = 8;
   localparam int BST  = 16;
   localparam int PMAX = 8;
   localparam int TCSR = 1;
   localparam int TRAS = 4;
   localparam int TRP  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic burst_start = 1'b0;
   logic refresh_grant = 1'b0;
   logic refresh_req, strobe_oe, ras_n, cas_n, we_n, ready, burst_done, overflow_err;

   int checks = 0;
   int errors = 0;
   int rf_total = 0;

   always #5 clk = ~clk;

   dref_refresh_seq #(
      .PWRUP_CYC(PW), .INTERVAL_CYC(IV), .WARM_CNT(WARM), .BURST_CNT(BST),
      .BURST_EN(1'b1), .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
      .refresh_grant(refresh_grant), .refresh_req(refresh_req),
      .strobe_oe(strobe_oe), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ready(ready), .burst_done(burst_done), .overflow_err(overflow_err));

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic check_ge(input string req, input int actual, input int lower);
      checks++;
      if (actual < lower) begin
         errors++;
         $display("FAIL %s: actual=%0d expected>=%0d", req, actual, lower);
      end
   endtask

   // Cycle-shape monitor (R4, R5), sampled away from the active edge
   logic p_ras = 1'b1, p_cas = 1'b1, seen_cycle = 1'b0;
   int lead = 0, low_len = 0, gap = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            rf_total++;
            check("R4 cas lead before ras", lead, TCSR);
            check("R4 we_n high at ras fall", int'(we_n), 1);
            check("R5 strobe_oe with grant", int'(strobe_oe && refresh_grant), 1);
         end
         if (!p_ras && ras_n) begin
            check("R4 ras low width", low_len, TRAS);
            check("R4 cas rises with ras", int'(cas_n), 1);
         end
         if (p_cas && !cas_n) begin
            check("R4 cas falls with ras high", int'(ras_n), 1);
            if (seen_cycle) check_ge("R4 precharge gap", gap, TRP);
            seen_cycle = 1'b1;
         end
         if (strobe_oe && !refresh_grant) check("R5 oe without grant", 1, 0);
         lead    = (!cas_n && ras_n) ? lead + 1 : 0;
         low_len = (!ras_n) ? low_len + 1 : 0;
         gap     = (cas_n && ras_n) ? gap + 1 : 0;
         p_ras   = ras_n;
         p_cas   = cas_n;
      end
   end

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 req in reset", int'(refresh_req), 0);
      check("R1 strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
      check("R1 flags low in reset", int'({strobe_oe, ready, burst_done, overflow_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req after release", int'(refresh_req), 0);
      check("R1 strobes high after release", int'({ras_n, cas_n}), 3);
   endtask

   task automatic t_powerup();
      // one edge already passed in t_reset
      burst_start = 1'b1;                 // R9: ignored, not ready
      @(negedge clk);
      burst_start = 1'b0;
      repeat (PW - 3) @(negedge clk);
      check("R2 req low before pause end", int'(refresh_req), 0);
      check("R2 no strobes during pause", int'(ras_n), 1);
      @(negedge clk);
      check("R2 req high after pause", int'(refresh_req), 1);
      check("R5 no oe without grant", int'(strobe_oe), 0);
   endtask

   task automatic t_warmup();
      int base;
      base = rf_total;
      refresh_grant = 1'b1;
      while (!ready) @(negedge clk);
      check("R3 warm-up cycle count", rf_total - base, WARM);
      check("R3 req drops with ready", int'(refresh_req), 0);
      check("R9 ignored burst left no work", int'(refresh_req), 0);
      repeat (20) @(negedge clk);
      check("R9 no burst cycles ran", rf_total - base, WARM);
      check("R3 ready held", int'(ready), 1);
   endtask

   task automatic t_postpone();
      int base;
      refresh_grant = 1'b0;
      while (!refresh_req) @(negedge clk);
      base = rf_total;
      repeat (2 * IV + IV / 2) @(negedge clk);
      check("R6 req held while postponed", int'(refresh_req), 1);
      check("R5 no cycles without grant", rf_total - base, 0);
      check("R5 oe low without grant", int'(strobe_oe), 0);
      refresh_grant = 1'b1;
      while (refresh_req) @(negedge clk);
      check("R6 postponed refreshes all run", rf_total - base, 3);
      check("R7 no overflow below limit", int'(overflow_err), 0);
   endtask

   task automatic t_burst();
      int base;
      int done_w;
      refresh_grant = 1'b1;
      while (!refresh_req) @(negedge clk);
      while (refresh_req) @(negedge clk);
      base = rf_total;
      burst_start = 1'b1;
      @(negedge clk);
      burst_start = 1'b0;
      while (!burst_done) @(negedge clk);
      check("R8 burst cycle count", rf_total - base, BST);
      done_w = 1;
      @(negedge clk);
      if (burst_done) done_w++;
      check("R8 done pulse width", done_w, 1);
      while (refresh_req) @(negedge clk);
   endtask

   task automatic t_overflow();
      int base;
      refresh_grant = 1'b0;
      while (!refresh_req) @(negedge clk);
      repeat (7 * IV + IV / 2) @(negedge clk);
      check("R7 no overflow at limit", int'(overflow_err), 0);
      repeat (2 * IV) @(negedge clk);
      check("R7 overflow flagged", int'(overflow_err), 1);
      base = rf_total;
      refresh_grant = 1'b1;
      while (refresh_req) @(negedge clk);
      check("R7 saturated count serviced", rf_total - base, PMAX);
      repeat (5) @(negedge clk);
      check("R7 overflow sticky", int'(overflow_err), 1);
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_warmup();
      t_postpone();
      t_burst();
      t_overflow();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (R1..R9 run): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule